// File: doc/BRIEF.md
# Execute Stage with Operand Forwarding

This block is the execute stage of a five-stage load/store pipeline. It takes the decoded instruction held in the ID/EX register (operation, destination, two source register numbers, the two values read from the register file and a 16-bit immediate). It decides for each ALU operand whether the register-file value is current, or whether a newer value must be taken early. That newer value can be the result the stage itself produced one cycle earlier (held in its EX/MEM output register) or the value now in write-back (MEM/WB). Dependent arithmetic instructions can then follow each other with no bubbles.

The selected operands go into a 32-bit ALU that does add, subtract, AND and OR. A second-operand multiplexer can substitute the sign-extended immediate for address arithmetic on loads and stores. The forwarded second source value goes on as store data. The ALU result, store data, destination number and write enable are captured in the stage's EX/MEM output register on every clock. The two 2-bit forward selects are also brought out so that the hazard decisions can be observed.

Top module: `exec_stage_fwd`

## Requirements
- R1: Each forward select uses the code 2'b00 to take the register-file value, 2'b10 to take the EX/MEM result and 2'b01 to take the MEM/WB value. The code 2'b11 never appears.
- R2: The first select is 2'b10 when the EX/MEM write enable is set, the EX/MEM destination is nonzero and it equals the first source number. The second select follows the same rule using the second source number.
- R3: When R2 does not apply, a select is 2'b01 when the MEM/WB write enable is set, the MEM/WB destination is nonzero and equals the source number, and the EX/MEM destination differs from that source number. In every other case the select is 2'b00.
- R4: Register number 0 is never forwarded. A source of 0 always gets select 2'b00, even right after an instruction that wrote register 0.
- R5: When both EX/MEM and MEM/WB could supply the same source, the EX/MEM result wins (select 2'b10).
- R6: The MEM/WB path is blocked whenever the EX/MEM destination number equals the source, even if the EX/MEM write enable is clear. The select is then 2'b00.
- R7: The ALU operation code 2'b00 is add, 2'b01 is subtract (first minus second), 2'b10 is AND and 2'b11 is OR. All arithmetic is modulo 2^32.
- R8: When the immediate enable is set, the second ALU operand is the 16-bit immediate sign-extended to 32 bits. The store data is still the forwarded second source value.
- R9: On every rising clock edge the output register captures the ALU result, the store data, the destination and the write enable. A synchronous reset clears all four to zero.
- R10: Back-to-back dependent instruction chains give the same results as sequential execution, with no nop inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_op | input | 2 | ALU operation code |
| id_use_imm | input | 1 | Select sign-extended immediate as second ALU operand |
| id_reg_write | input | 1 | Instruction writes its destination |
| id_rd | input | 5 | Destination register number |
| id_rs | input | 5 | First source register number |
| id_rt | input | 5 | Second source register number |
| id_rs_val | input | 32 | First source value from the register file |
| id_rt_val | input | 32 | Second source value from the register file |
| id_imm | input | 16 | Raw immediate field |
| wb_reg_write | input | 1 | Write enable of the instruction in write-back |
| wb_rd | input | 5 | Destination of the instruction in write-back |
| wb_value | input | 32 | Value being written back |
| fwd_a | output | 2 | Forward select for the first operand |
| fwd_b | output | 2 | Forward select for the second operand |
| ex_result | output | 32 | Registered ALU result |
| ex_store_data | output | 32 | Registered forwarded second source value |
| ex_rd | output | 5 | Registered destination number |
| ex_reg_write | output | 1 | Registered write enable |

## Verification
The hardest states to reach are those where both forwarding sources name the same register. One is the priority case, where EX/MEM and MEM/WB both match. The other is the blocking case, where an EX/MEM entry with its write enable clear still carries a matching destination number and so suppresses a valid MEM/WB match. The EX/MEM side comes only from the stage's own register, so the bench gets there through instruction order. It issues two writers of one register back to back and then a reader. For the blocking case it issues a writer, then a non-writing instruction whose destination field names the same register, then a reader. A behavioural pipeline model supplies stale register-file values and the write-back value for each cycle and predicts every select and result.

// File: rtl/exec_fwd_pkg.sv
package exec_fwd_pkg;

   typedef enum logic [1:0] {
      FWD_REGFILE = 2'b00,
      FWD_WB      = 2'b01,
      FWD_EXMEM   = 2'b10
   } fwd_sel_e;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_AND = 2'b10,
      ALU_OR  = 2'b11
   } alu_op_e;

   localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
   import exec_fwd_pkg::*;
#(
   parameter int unsigned REG_W = 5
) (
   input  logic             ex_we,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             wb_we,
   input  logic [REG_W-1:0] wb_rd,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output fwd_sel_e         sel_a,
   output fwd_sel_e         sel_b
);

   localparam logic [REG_W-1:0] ZERO_ID = '0;

   generate
      if (REG_W < 1) begin : g_bad_w
         $error("fwd_select_unit: REG_W must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0] src_id  [NUM_SRC];
   fwd_sel_e         src_sel [NUM_SRC];

   assign src_id[0] = src_a;
   assign src_id[1] = src_b;

   logic ex_live;
   logic wb_live;
   assign ex_live = ex_we && (ex_rd != ZERO_ID);
   assign wb_live = wb_we && (wb_rd != ZERO_ID);

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         logic ex_hit;
         logic wb_hit;
         assign ex_hit = ex_live && (ex_rd == src_id[s]);
         assign wb_hit = wb_live && (ex_rd != src_id[s]) && (wb_rd == src_id[s]);
         always_comb begin
            if (ex_hit)      src_sel[s] = FWD_EXMEM;
            else if (wb_hit) src_sel[s] = FWD_WB;
            else             src_sel[s] = FWD_REGFILE;
         end
      end
   endgenerate

   assign sel_a = src_sel[0];
   assign sel_b = src_sel[1];

endmodule

// File: rtl/operand_mux3.sv
module operand_mux3
   import exec_fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] exmem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (sel)
         FWD_EXMEM: y = exmem_val;
         FWD_WB:    y = wb_val;
         default:   y = rf_val;
      endcase
   end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
   import exec_fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/exec_stage_fwd.sv
module exec_stage_fwd
   import exec_fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned IMM_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        id_op,
   input  logic              id_use_imm,
   input  logic              id_reg_write,
   input  logic [REG_W-1:0]  id_rd,
   input  logic [REG_W-1:0]  id_rs,
   input  logic [REG_W-1:0]  id_rt,
   input  logic [DATA_W-1:0] id_rs_val,
   input  logic [DATA_W-1:0] id_rt_val,
   input  logic [IMM_W-1:0]  id_imm,
   input  logic              wb_reg_write,
   input  logic [REG_W-1:0]  wb_rd,
   input  logic [DATA_W-1:0] wb_value,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic [DATA_W-1:0] ex_result,
   output logic [DATA_W-1:0] ex_store_data,
   output logic [REG_W-1:0]  ex_rd,
   output logic              ex_reg_write
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   generate
      if (DATA_W < IMM_W) begin : g_bad_imm
         $error("exec_stage_fwd: IMM_W may not exceed DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("exec_stage_fwd: DATA_W too small");
      end
   endgenerate

   // EX/MEM output register
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] st_q;
   logic [REG_W-1:0]  rd_q;
   logic              we_q;

   fwd_sel_e sel_a;
   fwd_sel_e sel_b;

   fwd_select_unit #(.REG_W(REG_W)) u_fwd (
      .ex_we (we_q),
      .ex_rd (rd_q),
      .wb_we (wb_reg_write),
      .wb_rd (wb_rd),
      .src_a (id_rs),
      .src_b (id_rt),
      .sel_a (sel_a),
      .sel_b (sel_b)
   );

   logic [DATA_W-1:0] op_a;
   logic [DATA_W-1:0] op_b_fwd;

   operand_mux3 #(.DATA_W(DATA_W)) u_mux_a (
      .sel       (sel_a),
      .rf_val    (id_rs_val),
      .exmem_val (res_q),
      .wb_val    (wb_value),
      .y         (op_a)
   );

   operand_mux3 #(.DATA_W(DATA_W)) u_mux_b (
      .sel       (sel_b),
      .rf_val    (id_rt_val),
      .exmem_val (res_q),
      .wb_val    (wb_value),
      .y         (op_b_fwd)
   );

   logic [DATA_W-1:0] imm_ext;
   generate
      if (EXT_W == 0) begin : g_imm_full
         assign imm_ext = id_imm;
      end else begin : g_imm_sext
         assign imm_ext = {{EXT_W{id_imm[IMM_W-1]}}, id_imm};
      end
   endgenerate

   logic [DATA_W-1:0] alu_b;
   assign alu_b = id_use_imm ? imm_ext : op_b_fwd;

   alu_op_e           alu_op;
   logic [DATA_W-1:0] alu_y;
   assign alu_op = alu_op_e'(id_op);

   exec_alu #(.DATA_W(DATA_W)) u_alu (
      .op (alu_op),
      .a  (op_a),
      .b  (alu_b),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         st_q  <= '0;
         rd_q  <= '0;
         we_q  <= 1'b0;
      end else begin
         res_q <= alu_y;
         st_q  <= op_b_fwd;
         rd_q  <= id_rd;
         we_q  <= id_reg_write;
      end
   end

   assign fwd_a         = sel_a;
   assign fwd_b         = sel_b;
   assign ex_result     = res_q;
   assign ex_store_data = st_q;
   assign ex_rd         = rd_q;
   assign ex_reg_write  = we_q;

   // Checks placed beside the logic they guard
   assert_sel_code_R1: assert property (@(posedge clk) disable iff (rst)
      (sel_a != 2'b11) && (sel_b != 2'b11));

   assert_exmem_path_R2: assert property (@(posedge clk) disable iff (rst)
      (sel_a == FWD_EXMEM) |-> (op_a == res_q));

   assert_wb_path_R3: assert property (@(posedge clk) disable iff (rst)
      (sel_b == FWD_WB) |-> (op_b_fwd == wb_value));

   assert_zero_id_R4: assert property (@(posedge clk) disable iff (rst)
      (id_rs == '0) |-> (sel_a == FWD_REGFILE));

   assert_priority_R5: assert property (@(posedge clk) disable iff (rst)
      (we_q && rd_q != '0 && rd_q == id_rt && wb_reg_write && wb_rd == id_rt)
      |-> (sel_b == FWD_EXMEM));

   assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
      (!we_q && rd_q == id_rs) |-> (sel_a == FWD_REGFILE));

   assert_sub_R7: assert property (@(posedge clk) disable iff (rst)
      (alu_op == ALU_SUB) |-> ((alu_y + alu_b) == op_a));

   assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (res_q == $past(alu_y)) && (rd_q == $past(id_rd)));

   assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (res_q == '0) && (st_q == '0) && !we_q && (rd_q == '0));

endmodule

// File: tb/exec_stage_fwd_tb_top.sv
module exec_stage_fwd_tb_top;

   localparam int MAXI = 48;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  id_op;
   logic        id_use_imm, id_reg_write;
   logic [4:0]  id_rd, id_rs, id_rt;
   logic [31:0] id_rs_val, id_rt_val;
   logic [15:0] id_imm;
   logic        wb_reg_write;
   logic [4:0]  wb_rd;
   logic [31:0] wb_value;
   logic [1:0]  fwd_a, fwd_b;
   logic [31:0] ex_result, ex_store_data;
   logic [4:0]  ex_rd;
   logic        ex_reg_write;

   always #10 clk = ~clk;

   exec_stage_fwd dut_i (
      .clk(clk), .rst(rst), .id_op(id_op), .id_use_imm(id_use_imm),
      .id_reg_write(id_reg_write), .id_rd(id_rd), .id_rs(id_rs), .id_rt(id_rt),
      .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .id_imm(id_imm),
      .wb_reg_write(wb_reg_write), .wb_rd(wb_rd), .wb_value(wb_value),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .ex_result(ex_result),
      .ex_store_data(ex_store_data), .ex_rd(ex_rd), .ex_reg_write(ex_reg_write)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // program model
   logic [31:0] init_rf [32];
   logic [1:0]  p_op  [MAXI];
   logic [4:0]  p_rd  [MAXI];
   logic [4:0]  p_rs  [MAXI];
   logic [4:0]  p_rt  [MAXI];
   logic        p_we  [MAXI];
   logic        p_imm_en [MAXI];
   logic [15:0] p_imm [MAXI];
   logic [31:0] p_res [MAXI];
   logic [31:0] p_st  [MAXI];
   int n_ins;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic add_ins(logic [1:0] op, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt,
                          logic we, logic imm_en, logic [15:0] imm);
      p_op[n_ins] = op; p_rd[n_ins] = rd; p_rs[n_ins] = rs; p_rt[n_ins] = rt;
      p_we[n_ins] = we; p_imm_en[n_ins] = imm_en; p_imm[n_ins] = imm;
      n_ins++;
   endtask

   // register value visible to instructions up to index lim (inclusive)
   function automatic logic [31:0] reg_upto(logic [4:0] r, int lim);
      if (r == 5'd0) return 32'h0;
      for (int j = lim; j >= 0; j--)
         if (p_we[j] && p_rd[j] == r) return p_res[j];
      return init_rf[r];
   endfunction

   function automatic logic [1:0] exp_sel(int k, logic [4:0] src);
      logic       e_we, w_we;
      logic [4:0] e_rd, w_rd;
      e_we = (k >= 1) ? p_we[k-1] : 1'b0;
      e_rd = (k >= 1) ? p_rd[k-1] : 5'd0;
      w_we = (k >= 2) ? p_we[k-2] : 1'b0;
      w_rd = (k >= 2) ? p_rd[k-2] : 5'd0;
      if (e_we && e_rd != 0 && e_rd == src) return 2'b10;
      if (w_we && w_rd != 0 && w_rd == src && e_rd != src) return 2'b01;
      return 2'b00;
   endfunction

   function automatic string sel_tag(int k, logic [4:0] src);
      logic ex_m, wb_m;
      ex_m = (k >= 1) && p_we[k-1] && p_rd[k-1] == src && src != 0;
      wb_m = (k >= 2) && p_we[k-2] && p_rd[k-2] == src && src != 0;
      if (ex_m && wb_m) return "R5";
      if (ex_m) return "R2";
      if (wb_m && k >= 1 && p_rd[k-1] == src) return "R6";
      if (wb_m) return "R3";
      if (src == 0) return "R4";
      return "R1";
   endfunction

   function automatic logic [31:0] pick(logic [1:0] s, int k, logic [4:0] r);
      case (s)
         2'b10:   return p_res[k-1];
         2'b01:   return p_res[k-2];
         default: return reg_upto(r, k - 3);
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      id_op = 2'b00; id_use_imm = 0; id_reg_write = 0; id_rd = 0; id_rs = 0; id_rt = 0;
      id_rs_val = 0; id_rt_val = 0; id_imm = 0;
      wb_reg_write = 0; wb_rd = 0; wb_value = 0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R9 reset result", ex_result, 32'h0);
      chk("R9 reset store", ex_store_data, 32'h0);
      chk("R9 reset rd/we", {26'h0, ex_rd, ex_reg_write}, 32'h0);
   endtask

   task automatic run_program();
      for (int k = 0; k < n_ins; k++) begin
         logic [1:0]  sa, sb;
         logic [31:0] a, bf, b, y;
         @(negedge clk);
         id_op = p_op[k]; id_use_imm = p_imm_en[k]; id_reg_write = p_we[k];
         id_rd = p_rd[k]; id_rs = p_rs[k]; id_rt = p_rt[k]; id_imm = p_imm[k];
         id_rs_val = reg_upto(p_rs[k], k - 3);
         id_rt_val = reg_upto(p_rt[k], k - 3);
         wb_reg_write = (k >= 2) ? p_we[k-2] : 1'b0;
         wb_rd        = (k >= 2) ? p_rd[k-2] : 5'd0;
         wb_value     = (k >= 2) ? p_res[k-2] : 32'h0;
         sa = exp_sel(k, p_rs[k]);
         sb = exp_sel(k, p_rt[k]);
         a  = pick(sa, k, p_rs[k]);
         bf = pick(sb, k, p_rt[k]);
         b  = p_imm_en[k] ? {{16{p_imm[k][15]}}, p_imm[k]} : bf;   // R8
         case (p_op[k])                                              // R7
            2'b00: y = a + b;
            2'b01: y = a - b;
            2'b10: y = a & b;
            default: y = a | b;
         endcase
         p_res[k] = y;
         p_st[k]  = bf;
         #1;
         chk({sel_tag(k, p_rs[k]), " fwd_a"}, {30'h0, fwd_a}, {30'h0, sa});
         chk({sel_tag(k, p_rt[k]), " fwd_b"}, {30'h0, fwd_b}, {30'h0, sb});
         @(posedge clk);
         #1;
         chk("R7 result", ex_result, y);
         chk("R8 store data", ex_store_data, bf);
         chk("R9 rd/we", {26'h0, ex_rd, ex_reg_write}, {26'h0, p_rd[k], p_we[k]});
      end
   endtask

   initial begin
      #4_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, e, f, sum;
      int i9, isw1, ilw, isw2;
      rst = 1'b1;
      // program 1: document chain plus corner cases
      for (int r = 0; r < 32; r++) init_rf[r] = 32'h0;
      init_rf[1] = 32'hD8A3B8D4; init_rf[3] = 32'h63B9D6F2; init_rf[5] = 32'h0F0F0F0F;
      n_ins = 0;
      add_ins(2'b01, 5'd2, 5'd1, 5'd3, 1, 0, 16'h0);   // sub $2,$1,$3
      add_ins(2'b10, 5'd4, 5'd2, 5'd5, 1, 0, 16'h0);   // and $4,$2,$5
      add_ins(2'b11, 5'd4, 5'd4, 5'd2, 1, 0, 16'h0);   // or  $4,$4,$2
      i9 = n_ins;
      add_ins(2'b00, 5'd9, 5'd4, 5'd2, 1, 0, 16'h0);   // add $9,$4,$2
      isw1 = n_ins;
      add_ins(2'b00, 5'd0, 5'd0, 5'd9, 0, 1, 16'h0040);// store $9
      add_ins(2'b00, 5'd0, 5'd1, 5'd3, 1, 0, 16'h0);   // R4 writer of reg 0
      add_ins(2'b00, 5'd6, 5'd0, 5'd5, 1, 0, 16'h0);   // R4 reader of reg 0
      add_ins(2'b00, 5'd7, 5'd1, 5'd1, 1, 0, 16'h0);   // R5
      add_ins(2'b00, 5'd7, 5'd3, 5'd3, 1, 0, 16'h0);
      add_ins(2'b00, 5'd8, 5'd7, 5'd7, 1, 0, 16'h0);
      add_ins(2'b00, 5'd10, 5'd1, 5'd5, 1, 0, 16'h0);  // R6
      add_ins(2'b10, 5'd10, 5'd1, 5'd3, 0, 0, 16'h0);
      add_ins(2'b00, 5'd11, 5'd10, 5'd10, 1, 0, 16'h0);
      ilw = n_ins;
      add_ins(2'b00, 5'd12, 5'd1, 5'd0, 1, 1, 16'hFFF0); // R8 negative offset
      isw2 = n_ins;
      add_ins(2'b00, 5'd0, 5'd5, 5'd12, 0, 1, 16'h0008); // store forwarded $12
      add_ins(2'b11, 5'd13, 5'd12, 5'd12, 1, 0, 16'h0);  // MEM/WB on both
      do_reset();
      run_program();

      d = init_rf[1] - init_rf[3];
      e = (d & init_rf[5]) | d;
      f = e + d;
      chk("R10 chain $9", p_res[i9], f);
      chk("R10 chain $9 const", f, 32'hE9D3C3C4);
      chk("R10 store of $9", p_st[isw1], f);
      chk("R8 sign-extended offset", p_res[ilw], init_rf[1] - 32'd16);
      chk("R8 store data forwarded", p_st[isw2], init_rf[1] - 32'd16);

      // reset while live inputs are present
      @(negedge clk);
      rst = 1'b1;
      id_reg_write = 1; id_rd = 5'd3; id_rs_val = 32'h1234_5678;
      @(posedge clk);
      #1;
      chk("R9 mid-run reset result", ex_result, 32'h0);
      chk("R9 mid-run reset we", {31'h0, ex_reg_write}, 32'h0);

      // program 2: accumulate sixteen registers
      for (int r = 0; r < 32; r++) init_rf[r] = 32'h0;
      init_rf[1] = 8;  init_rf[2] = 4;  init_rf[3] = 7;  init_rf[4] = 12;
      init_rf[5] = 13; init_rf[6] = 19; init_rf[7] = 23; init_rf[8] = 43;
      init_rf[9] = 56; init_rf[10] = 32; init_rf[11] = 41; init_rf[12] = 4;
      init_rf[13] = 56; init_rf[14] = 7; init_rf[15] = 5; init_rf[16] = 66;
      n_ins = 0;
      add_ins(2'b00, 5'd17, 5'd1, 5'd2, 1, 0, 16'h0);
      for (int r = 3; r <= 16; r++)
         add_ins(2'b00, 5'd17, 5'd17, 5'(r), 1, 0, 16'h0);
      add_ins(2'b00, 5'd0, 5'd0, 5'd17, 0, 1, 16'h0100);
      do_reset();
      run_program();
      sum = 0;
      for (int r = 1; r <= 16; r++) sum = sum + init_rf[r];
      chk("R10 sum chain", p_res[n_ins-2], sum);
      chk("R10 sum value", sum, 32'd396);
      chk("R10 sum store", p_st[n_ins-1], sum);

      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule